// File: doc/BRIEF.md
# Bit-Serial Secure Memory Sequencer

This block sits behind the contact pins of a bit-addressed serial memory card. It turns the reset, clock and program pins into micro-operations and keeps the internal bit address counter. The micro-operations are address clear, step to the next bit, program a bit to 0 and program a bit to 1. It holds the bit store and shows the addressed bit on an open-drain data pin. The pin can only be pulled low or released. The card pins reach the block already synchronised to the system clock, and the block finds their edges by sampling them.

The address moves forward one bit on each falling edge of the card clock. The bit at the new address appears on the data pin without any further request. A program cycle changes the current bit in place and does not move the address. It takes effect only if the security logic, which sees the address output, asserts the permission input. With the default size of 1600 bits the counter stops at bit 1599.

Top module: `sbs_serial_seq`

## Requirements
- R1: While the reset pin is high, the address is 0. From the system clock edge after the reset pin is seen high, the data pin shows bit 0.
- R2: Card clock edges have no effect while the reset pin is high. A reset pin seen in the same cycle as a card clock fall clears the address and does not step it.
- R3: A falling edge of the card clock, with program and reset low, raises the address by one at the next system clock edge. The data pin then shows the new bit.
- R4: A rising edge of the card clock with program low leaves the address unchanged.
- R5: A rising edge of the card clock with program high, data input low and permission high sets the current bit to 0.
- R6: The same cycle with the data input high sets the current bit to 1.
- R7: A program cycle with permission low leaves the current bit unchanged.
- R8: The data pin is released (io_pull_low = 0) whenever the program pin is high. Otherwise it is pulled low exactly when the addressed bit is 0, and it is never driven high.
- R9: The address stops at NBITS-1: further falling edges leave it there.
- R10: After system reset every bit reads 1 and the address is 0.
- R11: A falling edge of the card clock with program high leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| rst_pin | input | 1 | Card reset pin, synchronised |
| clk_pin | input | 1 | Card clock pin, synchronised |
| pgm_pin | input | 1 | Card program pin, synchronised |
| io_in | input | 1 | Level sensed on the data pin (0 = write to 0, 1 = erase to 1 during a program cycle) |
| perm_ok | input | 1 | Permission from the security logic for the current address |
| addr | output | AW | Current bit address |
| io_pull_low | output | 1 | 1 = pull data pin low, 0 = release |

## Verification
A reset pulse and a card clock fall can arrive in the same system cycle. The bench provokes this by stepping to a non-zero address, raising the card clock, and then dropping it at the same moment the reset pin rises. The result is judged correct only if the address reads 0 and the data pin shows bit 0. Saturation and stepping also meet at the last bit: extra falling edges sent there must leave the address at NBITS-1.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ADDR_CLR,
        OP_STEP,
        OP_PROG0,
        OP_PROG1
    } sbs_op_e;
endpackage

// File: rtl/sbs_pin_decode.sv
module sbs_pin_decode
    import sbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rst_pin,
    input  logic    clk_pin,
    input  logic    pgm_pin,
    input  logic    io_in,
    output sbs_op_e op
);
    typedef struct packed {
        logic clk_prev;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       rise, fall;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = clk_pin;
        rise          = clk_pin & ~st_q.clk_prev;
        fall          = ~clk_pin & st_q.clk_prev;
        op            = OP_IDLE;
        if (!rst_n) begin
            op = OP_IDLE;
        end else if (rst_pin) begin
            op = OP_ADDR_CLR;
        end else if (pgm_pin) begin
            if (rise) op = io_in ? OP_PROG1 : OP_PROG0;
        end else if (fall) begin
            op = OP_STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sbs_addr_ctr.sv
module sbs_addr_ctr
    import sbs_pkg::*;
#(
    parameter int NBITS = 1600,
    localparam int AW   = $clog2(NBITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sbs_op_e       op,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST = AW'(NBITS - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op)
            OP_ADDR_CLR: st_d.addr = '0;
            OP_STEP:     if (st_q.addr != LAST) st_d.addr = st_q.addr + 1'b1;
            default:     st_d.addr = st_q.addr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;
endmodule

// File: rtl/sbs_bit_store.sv
module sbs_bit_store
    import sbs_pkg::*;
#(
    parameter int NBITS = 1600,
    localparam int AW   = $clog2(NBITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sbs_op_e       op,
    input  logic          perm_ok,
    input  logic [AW-1:0] addr,
    output logic          rd_bit
);
    typedef struct packed {
        logic [NBITS-1:0] bits;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (perm_ok) begin
            if (op == OP_PROG0) st_d.bits[addr] = 1'b0;
            if (op == OP_PROG1) st_d.bits[addr] = 1'b1;
        end
        rd_bit = st_q.bits[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sbs_serial_seq.sv
module sbs_serial_seq
    import sbs_pkg::*;
#(
    parameter int NBITS = 1600,
    localparam int AW   = $clog2(NBITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_pin,
    input  logic          clk_pin,
    input  logic          pgm_pin,
    input  logic          io_in,
    input  logic          perm_ok,
    output logic [AW-1:0] addr,
    output logic          io_pull_low
);
    sbs_op_e op_w;
    logic    rd_bit_w;

    sbs_pin_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_pin (rst_pin),
        .clk_pin (clk_pin),
        .pgm_pin (pgm_pin),
        .io_in   (io_in),
        .op      (op_w)
    );

    sbs_addr_ctr #(.NBITS(NBITS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op_w),
        .addr  (addr)
    );

    sbs_bit_store #(.NBITS(NBITS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op_w),
        .perm_ok (perm_ok),
        .addr    (addr),
        .rd_bit  (rd_bit_w)
    );

    // Open drain: the only active level is low.
    assign io_pull_low = ~pgm_pin & ~rd_bit_w;
endmodule

// File: rtl/sbs_serial_seq_chk.sv
module sbs_serial_seq_chk
    import sbs_pkg::*;
#(
    parameter int NBITS = 1600,
    localparam int AW   = $clog2(NBITS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rst_pin,
    input logic          pgm_pin,
    input logic          perm_ok,
    input logic          io_pull_low,
    input logic [AW-1:0] addr,
    input sbs_op_e       op,
    input logic          rd_bit
);
    localparam logic [AW-1:0] LAST = AW'(NBITS - 1);

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin |=> addr == '0);

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP && addr != LAST) |=> addr == $past(addr) + 1'b1);

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP && addr == LAST) |=> addr == LAST);

    a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= LAST);

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_pin |-> !io_pull_low);

    a_r5_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PROG0 && perm_ok) |=> !rd_bit);

    a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!perm_ok && op != OP_ADDR_CLR && op != OP_STEP) |=> $stable(rd_bit));

    a_r11_prog_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_pin && !rst_pin) |=> $stable(addr));
endmodule

bind sbs_serial_seq sbs_serial_seq_chk #(.NBITS(NBITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_pin     (rst_pin),
    .pgm_pin     (pgm_pin),
    .perm_ok     (perm_ok),
    .io_pull_low (io_pull_low),
    .addr        (addr),
    .op          (op_w),
    .rd_bit      (rd_bit_w)
);

// File: tb/test_sbs_serial_seq.sv
module test_sbs_serial_seq;
    localparam int N  = 48;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n, rst_pin, clk_pin, pgm_pin, io_in, perm_ok;
    logic [AW-1:0] addr;
    logic          io_pull_low;

    int       n_cmp = 0;
    int       n_bad = 0;
    bit       done  = 1'b0;
    logic [N-1:0] mdl;
    int       m_addr;

    always #2 clk = ~clk;

    sbs_serial_seq #(.NBITS(N)) i_sbs_serial_seq (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .clk_pin(clk_pin),
        .pgm_pin(pgm_pin), .io_in(io_in), .perm_ok(perm_ok),
        .addr(addr), .io_pull_low(io_pull_low)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic look(string tag);
        chk({tag, " addr"}, int'(addr), m_addr);
        chk({tag, " pin"}, int'(io_pull_low), pgm_pin ? 0 : int'(!mdl[m_addr]));
    endtask

    task automatic tick();
        @(negedge clk) clk_pin = 1'b1;
        @(negedge clk) clk_pin = 1'b0;
        if (m_addr < N - 1) m_addr++;
        @(negedge clk);
    endtask

    task automatic prog(logic v, logic perm);
        @(negedge clk) begin pgm_pin = 1'b1; io_in = v; perm_ok = perm; end
        @(negedge clk) clk_pin = 1'b1;
        @(negedge clk) begin clk_pin = 1'b0; perm_ok = 1'b0; end
        @(negedge clk);
        chk("R8 released in program", int'(io_pull_low), 0);
        chk("R11 addr held", int'(addr), m_addr);
        pgm_pin = 1'b0; io_in = 1'b0;
        if (perm) mdl[m_addr] = v;
        @(negedge clk);
        look(v ? (perm ? "R6" : "R7") : (perm ? "R5" : "R7"));
    endtask

    task automatic pin_reset();
        @(negedge clk) rst_pin = 1'b1;
        @(negedge clk) chk("R1 reset addr", int'(addr), 0);
        rst_pin = 1'b0;
        m_addr = 0;
        @(negedge clk) look("R1");
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < N; i++) begin
            look(tag);
            tick();
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rst_pin = 0; clk_pin = 0; pgm_pin = 0; io_in = 0; perm_ok = 0;
        mdl = '1; m_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk) look("R10");

        sweep("R3 R10");
        chk("R9 at last", int'(addr), N - 1);
        tick(); tick();
        chk("R9 saturated", int'(addr), N - 1);

        pin_reset();
        for (int i = 0; i < N; i++) begin
            if (i % 3 == 0)      prog(1'b0, 1'b1);
            else if (i % 7 == 0) prog(1'b0, 1'b0);
            tick();
        end
        pin_reset();
        sweep("R5 R7 readback");

        pin_reset();
        for (int i = 0; i < N; i++) begin
            if (i % 6 == 0)      prog(1'b1, 1'b1);
            else if (i % 4 == 0) prog(1'b1, 1'b0);
            tick();
        end
        pin_reset();
        sweep("R6 R7 readback");

        pin_reset();
        @(negedge clk) clk_pin = 1'b1;
        @(negedge clk) chk("R4 rise no step", int'(addr), 0);
        clk_pin = 1'b0; m_addr = 1;
        @(negedge clk) look("R3 step after fall");

        @(negedge clk) pgm_pin = 1'b1;
        @(negedge clk) clk_pin = 1'b1;
        @(negedge clk) clk_pin = 1'b0;
        @(negedge clk) chk("R11 fall with program", int'(addr), 1);
        pgm_pin = 1'b0;

        repeat (4) tick();
        @(negedge clk) rst_pin = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) clk_pin = 1'b1;
            @(negedge clk) clk_pin = 1'b0;
            @(negedge clk) chk("R2 clock during reset", int'(addr), 0);
        end
        rst_pin = 1'b0; m_addr = 0;

        repeat (5) tick();
        @(negedge clk) clk_pin = 1'b1;
        @(negedge clk) begin clk_pin = 1'b0; rst_pin = 1'b1; end
        @(negedge clk) chk("R2 reset beats fall", int'(addr), 0);
        rst_pin = 1'b0; m_addr = 0;
        @(negedge clk) look("R1 bit 0 shown");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule